// File: doc/BRIEF.md
# I2C Address-Match Sleep Wakeup Controller

This block lets an I2C target keep listening while the rest of the system sleeps. It watches the already-synchronized SCL and SDA lines for a start condition and shifts in the first byte of the transfer. It then compares the top seven bits of that byte with a programmable device address. The last bit of the byte (the read/write bit) is captured and made visible, but it plays no part in the comparison.

On a match the block raises a one-cycle wakeup interrupt and holds SCL low, so the controller on the bus waits while the system clock source starts. Once the oscillator reports ready, the block drives SDA low to acknowledge the address and then lets SCL go. On a mismatch it leaves SDA released, which the controller sees as a NACK, and the system stays asleep.

The block takes part only while it is enabled, one of its two bus-owner qualifiers is set, the sleep controller's power-down signal is high and address wakeup is armed. When any of these is missing, it ignores the bus and keeps both lines released.

Top module: `i2c_wake_ctrl`

## Requirements
- R1: The block responds only while `slave_en_i`=1, (`i2c_on_i` or `usb_en_i`)=1, `pd_i`=1 and `addr_wake_en_i`=1. Otherwise it ignores all bus activity, never pulses `wake_irq_o` and keeps `scl_hold_o`=0 and `sda_low_o`=0. Losing the gate in the middle of a sequence returns the block to idle.
- R2: Address reception begins only on a start condition, which is SDA falling while SCL is high. Bits clocked without a preceding start are ignored.
- R3: Address bits are sampled on rising SCL edges, most significant bit first. The first seven bits are compared with `own_addr_i`. The eighth bit is presented on `rw_o` and is excluded from the comparison.
- R4: On a match, `wake_irq_o` is high for exactly one cycle and `scl_hold_o` rises. Both are visible one clock edge after the falling SCL edge that ends the eighth bit.
- R5: After a match, `scl_hold_o` stays high for as long as `osc_ready_i` is low, however long that is, and `sda_low_o` stays 0 during that wait.
- R6: One edge after `osc_ready_i` is seen high, `sda_low_o` goes to 1 while `scl_hold_o` is still 1. One edge later `scl_hold_o` goes to 0 and `sda_low_o` stays 1. One edge after the next falling SCL edge, both outputs are 0.
- R7: On a mismatch there is no interrupt, no SCL hold and no SDA drive through the ninth clock (a NACK). The block then returns to idle.
- R8: A stop condition (SDA rising while SCL is high) or a repeated start during address reception aborts the sequence and returns the block to idle, with no response to the rest of that byte.
- R9: During and directly after reset, `wake_irq_o`, `scl_hold_o` and `sda_low_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slave_en_i | input | 1 | Target enable |
| i2c_on_i | input | 1 | Bus-owner qualifier A |
| usb_en_i | input | 1 | Bus-owner qualifier B |
| pd_i | input | 1 | Power-down indication from sleep control, high while asleep |
| addr_wake_en_i | input | 1 | Arms wakeup on address match |
| own_addr_i | input | 7 | Device address to compare |
| osc_ready_i | input | 1 | System clock source is running |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| wake_irq_o | output | 1 | One-cycle wakeup interrupt on match |
| scl_hold_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low (ACK) |
| rw_o | output | 1 | Captured read/write bit of the last address byte |

## Verification
Every result is registered once after the block samples the bus. A bus event driven just after clock edge N therefore shows at the outputs after edge N+1. The hold and the interrupt appear one edge after the eighth SCL fall. The ACK appears one edge after the oscillator-ready input rises, and SCL is released one edge after that. The bench changes inputs one nanosecond after a rising edge and samples on the falling edge that follows the next rising edge, so each check lands in the first cycle the result is due. During the oscillator delay the hold is checked every cycle. Monitors count interrupt, hold and drive cycles over whole transfers, so that mismatch, gated and aborted cases show no activity at all.

// File: rtl/i2c_wake_pkg.sv
package i2c_wake_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HOLD,
    ST_ACK_SU,
    ST_ACK,
    ST_NACK
  } wake_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
  } bus_evt_t;

endpackage

// File: rtl/i2c_wake_gate.sv
module i2c_wake_gate #(
  parameter int unsigned QUAL_N = 2
) (
  input  logic              slave_en_i,
  input  logic [QUAL_N-1:0] qual_i,
  input  logic              pd_i,
  input  logic              addr_wake_en_i,
  output logic              armed_o
);

  // any one bus-owner qualifier is enough
  logic qual_any;
  assign qual_any = |qual_i;

  assign armed_o = slave_en_i & qual_any & pd_i & addr_wake_en_i;

endmodule

// File: rtl/i2c_wake_bus_mon.sv
module i2c_wake_bus_mon
  import i2c_wake_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    evt_o.start    = scl_q & scl_i & sda_q & ~sda_i;
    evt_o.stop     = scl_q & scl_i & ~sda_q & sda_i;
    evt_o.scl_rise = ~scl_q & scl_i;
    evt_o.scl_fall = scl_q & ~scl_i;
  end

endmodule

// File: rtl/i2c_wake_addr_rx.sv
module i2c_wake_addr_rx #(
  parameter int unsigned FRAME_BITS = 8,
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  shift_i,
  input  logic                  sda_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  full_o
);

  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] sh_q;

  assign full_o  = (cnt_q == CNT_W'(FRAME_BITS));
  assign frame_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (shift_i && !full_o) begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= {sh_q[FRAME_BITS-2:0], sda_i};  // msb first
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_BITS));

  p_shift_counts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clear_i && !full_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/i2c_wake_fsm.sv
module i2c_wake_fsm
  import i2c_wake_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        armed_i,
  input  bus_evt_t    evt_i,
  input  logic        full_i,
  input  logic        match_i,
  input  logic        osc_ready_i,
  output wake_state_e state_o,
  output logic        rx_clear_o,
  output logic        rx_shift_o,
  output logic        irq_o
);

  wake_state_e state_q, state_d;
  logic        irq_q;

  always_comb begin
    state_d    = state_q;
    rx_clear_o = 1'b0;
    if (!armed_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (evt_i.start) begin
          state_d    = ST_ADDR;
          rx_clear_o = 1'b1;
        end
        ST_ADDR: begin
          if (evt_i.start || evt_i.stop)        state_d = ST_IDLE;
          else if (full_i && evt_i.scl_fall)    state_d = match_i ? ST_HOLD : ST_NACK;
        end
        ST_HOLD:   if (osc_ready_i) state_d = ST_ACK_SU;
        ST_ACK_SU: state_d = ST_ACK;
        ST_ACK:    if (evt_i.scl_fall || evt_i.stop) state_d = ST_IDLE;
        ST_NACK:   if (evt_i.scl_fall || evt_i.stop) state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  assign rx_shift_o = (state_q == ST_ADDR) && evt_i.scl_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= (state_d == ST_HOLD) && (state_q != ST_HOLD);
    end
  end

  assign state_o = state_q;
  assign irq_o   = irq_q;

  p_irq_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);

  p_hold_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && armed_i && !osc_ready_i) |=> (state_q == ST_HOLD));

  p_ack_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK_SU) |=> (state_q == ST_ACK || state_q == ST_IDLE));

  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && (evt_i.start || evt_i.stop)) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/i2c_wake_ctrl.sv
module i2c_wake_ctrl
  import i2c_wake_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned FRAME_BITS = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_en_i,
  input  logic              i2c_on_i,
  input  logic              usb_en_i,
  input  logic              pd_i,
  input  logic              addr_wake_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              osc_ready_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              wake_irq_o,
  output logic              scl_hold_o,
  output logic              sda_low_o,
  output logic              rw_o
);

  logic                  armed;
  bus_evt_t              evt;
  logic [FRAME_BITS-1:0] frame;
  logic                  full, match, rx_clear, rx_shift;
  wake_state_e           state;

  i2c_wake_gate #(.QUAL_N(2)) u_gate (
    .slave_en_i     (slave_en_i),
    .qual_i         ({usb_en_i, i2c_on_i}),
    .pd_i           (pd_i),
    .addr_wake_en_i (addr_wake_en_i),
    .armed_o        (armed)
  );

  i2c_wake_bus_mon u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .evt_o  (evt)
  );

  i2c_wake_addr_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (rx_clear),
    .shift_i (rx_shift),
    .sda_i   (sda_i),
    .frame_o (frame),
    .full_o  (full)
  );

  // r/w bit excluded from compare
  assign match = (frame[FRAME_BITS-1:1] == own_addr_i);
  assign rw_o  = frame[0];

  i2c_wake_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .armed_i     (armed),
    .evt_i       (evt),
    .full_i      (full),
    .match_i     (match),
    .osc_ready_i (osc_ready_i),
    .state_o     (state),
    .rx_clear_o  (rx_clear),
    .rx_shift_o  (rx_shift),
    .irq_o       (wake_irq_o)
  );

  assign scl_hold_o = (state == ST_HOLD) || (state == ST_ACK_SU);
  assign sda_low_o  = (state == ST_ACK_SU) || (state == ST_ACK);

  p_gate_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> (!scl_hold_o && !sda_low_o && !wake_irq_o));

  p_irq_with_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |-> scl_hold_o);

  p_ack_before_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> scl_hold_o);

  p_nack_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && evt.scl_fall && !match && state == ST_ADDR) |=> (!scl_hold_o && !wake_irq_o));

endmodule

// File: tb/i2c_wake_ctrl_tb_top.sv
module i2c_wake_ctrl_tb_top;

  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic slave_en = 1'b1, i2c_on = 1'b1, usb_en = 1'b0, pd = 1'b1, wake_en = 1'b1;
  logic osc_ready = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic wake_irq, scl_hold, sda_low, rw;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0, hold_cnt = 0, drv_cnt = 0;

  always #2 clk = ~clk;

  i2c_wake_ctrl dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .slave_en_i     (slave_en),
    .i2c_on_i       (i2c_on),
    .usb_en_i       (usb_en),
    .pd_i           (pd),
    .addr_wake_en_i (wake_en),
    .own_addr_i     (OWN),
    .osc_ready_i    (osc_ready),
    .scl_i          (scl),
    .sda_i          (sda),
    .wake_irq_o     (wake_irq),
    .scl_hold_o     (scl_hold),
    .sda_low_o      (sda_low),
    .rw_o           (rw)
  );

  always @(negedge clk) begin
    if (wake_irq) irq_cnt++;
    if (scl_hold) hold_cnt++;
    if (sda_low)  drv_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sample();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr_mon();
    irq_cnt = 0; hold_cnt = 0; drv_cnt = 0;
  endtask

  task automatic bus_start();
    sda = 1'b1; wt(4);
    scl = 1'b1; wt(4);
    sda = 1'b0; wt(8);
    scl = 1'b0; wt(4);
  endtask

  task automatic bus_stop();
    wt(4);
    sda = 1'b0; wt(4);
    scl = 1'b1; wt(4);
    sda = 1'b1; wt(8);
  endtask

  // top n bits of b, msb first; ends just after the last scl fall
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda = b[i]; wt(4);
      scl = 1'b1; wt(8);
      scl = 1'b0;
      if (i != 8 - n) wt(4);
    end
  endtask

  task automatic ninth_clk();
    wt(4);
    scl = 1'b1; wt(8);
    scl = 1'b0;
  endtask

  task automatic set_gate(input logic se, input logic io, input logic ue,
                          input logic p, input logic we);
    slave_en = se; i2c_on = io; usb_en = ue; pd = p; wake_en = we;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_eq("R9 irq in reset", int'(wake_irq), 0);
    chk_eq("R9 hold in reset", int'(scl_hold), 0);
    chk_eq("R9 sda in reset", int'(sda_low), 0);
    wt(2);
    rst_ni = 1'b1;
    sample();
    chk_eq("R9 outputs after reset", int'({wake_irq, scl_hold, sda_low}), 0);
  endtask

  task automatic t_match(input logic rw_bit, input int delay);
    clr_mon();
    osc_ready = 1'b0;
    bus_start();
    send_bits({OWN, rw_bit}, 8);
    sample();
    chk_eq("R4 irq on match", int'(wake_irq), 1);
    chk_eq("R4 hold on match", int'(scl_hold), 1);
    chk_eq("R3 rw captured", int'(rw), int'(rw_bit));
    sample();
    chk_eq("R4 irq single pulse", int'(wake_irq), 0);
    for (int i = 0; i < delay; i++) begin
      chk(scl_hold && !sda_low, "R5 hold during osc wait",
          int'({scl_hold, sda_low}), 2);
      sample();
    end
    osc_ready = 1'b1;
    sample();
    chk_eq("R6 ack setup sda", int'(sda_low), 1);
    chk_eq("R6 ack setup hold", int'(scl_hold), 1);
    sample();
    chk_eq("R6 release scl", int'(scl_hold), 0);
    chk_eq("R6 ack kept", int'(sda_low), 1);
    wt(4);
    scl = 1'b1; wt(8);
    chk_eq("R6 ack while scl high", int'(sda_low), 1);
    scl = 1'b0;
    sample();
    chk_eq("R6 lines free after ack", int'({scl_hold, sda_low}), 0);
    bus_stop();
    osc_ready = 1'b0;
    chk_eq("R4 one irq per match", irq_cnt, 1);
  endtask

  task automatic t_mismatch();
    clr_mon();
    osc_ready = 1'b0;
    bus_start();
    send_bits({OWN ^ 7'h01, 1'b0}, 8);
    sample();
    chk_eq("R7 no hold on mismatch", int'(scl_hold), 0);
    ninth_clk();
    bus_stop();
    chk_eq("R7 no irq", irq_cnt, 0);
    chk_eq("R7 no hold", hold_cnt, 0);
    chk_eq("R7 sda released (nack)", drv_cnt, 0);
    clr_mon();
    // rw bit differing must not spoil a match (R3)
    osc_ready = 1'b1;
    bus_start();
    send_bits({OWN, 1'b1}, 8);
    sample();
    chk_eq("R3 rw excluded from compare", int'(scl_hold), 1);
    ninth_clk();
    bus_stop();
    osc_ready = 1'b0;
  endtask

  task automatic t_gated(input string req, input logic se, input logic io,
                         input logic ue, input logic p, input logic we);
    set_gate(se, io, ue, p, we);
    clr_mon();
    osc_ready = 1'b1;
    bus_start();
    send_bits({OWN, 1'b0}, 8);
    ninth_clk();
    bus_stop();
    chk_eq({req, " no irq"}, irq_cnt, 0);
    chk_eq({req, " no line drive"}, hold_cnt + drv_cnt, 0);
    osc_ready = 1'b0;
    set_gate(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_gate_drop();
    clr_mon();
    osc_ready = 1'b0;
    bus_start();
    send_bits({OWN, 1'b0}, 8);
    wt(3);
    pd = 1'b0;
    sample();
    chk_eq("R1 gate drop releases scl", int'(scl_hold), 0);
    pd = 1'b1;
    ninth_clk();
    bus_stop();
  endtask

  task automatic t_abort_stop();
    clr_mon();
    osc_ready = 1'b1;
    bus_start();
    send_bits({OWN, 1'b0}, 4);
    bus_stop();
    scl = 1'b0; wt(4);
    // no start: bits must be ignored (R2)
    send_bits({OWN, 1'b0}, 8);
    ninth_clk();
    wt(4);
    sda = 1'b1; scl = 1'b1; wt(8);
    chk_eq("R8 stop abort no irq", irq_cnt, 0);
    chk_eq("R2 no start no hold", hold_cnt + drv_cnt, 0);
    osc_ready = 1'b0;
  endtask

  task automatic t_abort_restart();
    clr_mon();
    osc_ready = 1'b1;
    bus_start();
    send_bits({OWN, 1'b0}, 3);
    wt(4);
    bus_start();
    send_bits({OWN, 1'b0}, 8);
    ninth_clk();
    bus_stop();
    chk_eq("R8 restart abort no irq", irq_cnt, 0);
    chk_eq("R8 restart abort no drive", hold_cnt + drv_cnt, 0);
    osc_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    wt(4);
    t_match(1'b0, 25);
    t_match(1'b1, 3);
    t_mismatch();
    t_gated("R1 pd low", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    t_gated("R1 no qualifier", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    t_gated("R1 disabled", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    t_gated("R1 wake unarmed", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    set_gate(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    t_match(1'b0, 5);  // R1 second qualifier path
    set_gate(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    t_gate_drop();
    t_abort_stop();
    t_abort_restart();
    t_match(1'b1, 1);
    finish_run();
  end

endmodule